// File: doc/BRIEF.md
# Sticky Interrupt Status Unit with Overrun Guard

This block gathers the interrupt sources of an audio/modem controller into one 16-bit status word. A bus system-error condition, two general-purpose pin events, a line-in FIFO overrun and two line-in descriptor completions each set a sticky status bit. Software reads the word and clears bits by writing ones to them. A single registered interrupt line goes high whenever a status bit is set and enabled. The system-error bit has its enable in the top bit of the same word. The three line-in bits are enabled by a separate control input.

The block also sits in the line-in sample path. Samples arrive on a valid/ready stream whose ready is always high. A live audio source cannot be stalled, so there is no back-pressure. A sample offered while the FIFO reports full is dropped, and it raises the overrun flag. While that flag is set, every later sample is also dropped until software clears the flag. A sample that is accepted goes to the FIFO write port in the same cycle.

Top module: `isu_top`

## Requirements
- R1: After reset `reg_rd_data` is 0x0000 and `irq` is 0.
- R2: Bits 13..10 of `reg_rd_data` always read 0, and writes to them have no effect.
- R3: Bit 15 is a read/write enable, loaded from `reg_wr_data[15]` on every write. Bit 14 sets on an edge where bit 15 is 1 and `cfg_err_status` is 1, and never sets otherwise.
- R4: A one-cycle pulse on `gpio_evt[1]` sets bit 9, and a pulse on `gpio_evt[0]` sets bit 8. Each bit stays set after the pulse ends.
- R5: A write with a 1 in bit 14, 9, 8, 7, 6 or 5 clears that status bit. A 0 in those positions leaves the bit unchanged.
- R6: If a set condition and a write-1-clear hit the same status bit in the same cycle, the bit is 1 afterwards.
- R7: Bit 7 sets when `smp_valid` is high while `fifo_full` is high. `smp_ready` is always 1.
- R8: `fifo_wr_en` equals `smp_valid & ~fifo_full & ~bit7` in the same cycle, and `fifo_wr_data` carries `smp_data`. Samples are therefore dropped while the overrun flag is set.
- R9: A pulse on `li_curr_done` sets bit 6, and a pulse on `li_last_done` sets bit 5.
- R10: `irq` is a register. In any cycle it is 1 exactly when the status shown on `reg_rd_data` in that cycle has any of the following:
  - bit 14 together with bit 15;
  - bit 9;
  - bit 8;
  - bit 7 with `li_irq_en[2]`;
  - bit 6 with `li_irq_en[1]`;
  - bit 5 with `li_irq_en[0]`.
  
  The enables are those sampled at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 16 | Write data (bit 15 enable, ones clear status) |
| reg_rd_data | output | 16 | Current register contents |
| cfg_err_status | input | 1 | External system-error status level |
| gpio_evt | input | 2 | General-purpose pin event pulses |
| li_curr_done | input | 1 | Current line-in descriptor finished |
| li_last_done | input | 1 | Last line-in descriptor finished |
| li_irq_en | input | 3 | Enables for status bits 7, 6, 5 |
| smp_valid | input | 1 | Line-in sample valid |
| smp_ready | output | 1 | Always 1; no back-pressure |
| smp_data | input | SMP_W | Line-in sample |
| fifo_full | input | 1 | FIFO full indication |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | SMP_W | FIFO write data |
| irq | output | 1 | Registered combined interrupt |

## Verification
The bench drives each event source alone, then several at once, and follows each step with single-bit and multi-bit clearing writes. This separates per-bit clearing from clearing of the whole word. Writes of zeros and writes to the reserved field check that nothing changes as a side effect. Set and clear are also made to collide on the same edge. The system-error bit is tried with its enable off and with the external status low, which shows that both gates are needed. Samples are streamed while the FIFO is not full, at the full boundary, after the overrun flag is set and after it is cleared. This shows that dropping is tied to the flag and not to the full level alone. The line-in enables are switched one at a time to show that each gates only its own bit into `irq`.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int REG_W    = 16;
  localparam int IE_BIT   = 15;
  localparam int SERR_BIT = 14;
  localparam int GP1_BIT  = 9;
  localparam int GP0_BIT  = 8;
  localparam int OVR_BIT  = 7;
  localparam int CUR_BIT  = 6;
  localparam int LST_BIT  = 5;
  localparam int LI_N     = 3;
  localparam logic [REG_W-1:0] STATUS_MASK =
    (REG_W'(1) << SERR_BIT) | (REG_W'(1) << GP1_BIT) | (REG_W'(1) << GP0_BIT) |
    (REG_W'(1) << OVR_BIT)  | (REG_W'(1) << CUR_BIT) | (REG_W'(1) << LST_BIT);
endpackage

// File: rtl/isu_sticky_bit.sv
module isu_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o,
  output logic q_next_o
);
  logic q_r;
  // a set on the same edge as a clear keeps the bit high
  always_comb begin
    q_next_o = q_r;
    if (clr_i) q_next_o = 1'b0;
    if (set_i) q_next_o = 1'b1;
  end
  always_ff @(posedge clk) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_next_o;
  end
  assign q_o = q_r;
endmodule

// File: rtl/isu_ovr_gate.sv
module isu_ovr_gate #(
  parameter int SMP_W = 32
) (
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             fifo_full,
  input  logic             ovr_flag,
  output logic             fifo_wr_en,
  output logic [SMP_W-1:0] fifo_wr_data,
  output logic             ovr_evt
);
  assign ovr_evt      = smp_valid & fifo_full;
  assign fifo_wr_en   = smp_valid & ~fifo_full & ~ovr_flag;
  assign fifo_wr_data = smp_data;
endmodule

// File: rtl/isu_irq_reduce.sv
module isu_irq_reduce
  import isu_pkg::*;
(
  input  logic [REG_W-1:0] status,
  input  logic [LI_N-1:0]  li_en,
  output logic             irq_d
);
  logic [LI_N-1:0] li_bits;
  assign li_bits = {status[OVR_BIT], status[CUR_BIT], status[LST_BIT]};
  assign irq_d = (status[SERR_BIT] & status[IE_BIT]) | status[GP1_BIT] |
                 status[GP0_BIT] | (|(li_bits & li_en));
endmodule

// File: rtl/isu_top.sv
module isu_top
  import isu_pkg::*;
#(
  parameter int SMP_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [15:0]      reg_wr_data,
  output logic [15:0]      reg_rd_data,
  input  logic             cfg_err_status,
  input  logic [1:0]       gpio_evt,
  input  logic             li_curr_done,
  input  logic             li_last_done,
  input  logic [2:0]       li_irq_en,
  input  logic             smp_valid,
  output logic             smp_ready,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             fifo_full,
  output logic             fifo_wr_en,
  output logic [SMP_W-1:0] fifo_wr_data,
  output logic             irq
);
  logic [REG_W-1:0] set_vec, clr_vec, st_q, st_next;
  logic ovr_evt, irq_d, irq_r;

  isu_ovr_gate #(.SMP_W(SMP_W)) u_gate (
    .smp_valid(smp_valid), .smp_data(smp_data), .fifo_full(fifo_full),
    .ovr_flag(st_q[OVR_BIT]), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_data(fifo_wr_data), .ovr_evt(ovr_evt));

  always_comb begin
    set_vec = '0;
    set_vec[SERR_BIT] = st_q[IE_BIT] & cfg_err_status;
    set_vec[GP1_BIT]  = gpio_evt[1];
    set_vec[GP0_BIT]  = gpio_evt[0];
    set_vec[OVR_BIT]  = ovr_evt;
    set_vec[CUR_BIT]  = li_curr_done;
    set_vec[LST_BIT]  = li_last_done;
  end
  assign clr_vec = reg_wr_en ? reg_wr_data : '0;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (STATUS_MASK[b]) begin : g_st
      isu_sticky_bit u_bit (
        .clk(clk), .rst_n(rst_n), .set_i(set_vec[b]), .clr_i(clr_vec[b]),
        .q_o(st_q[b]), .q_next_o(st_next[b]));
    end else if (b == IE_BIT) begin : g_ie
      logic ie_r;
      always_ff @(posedge clk) begin
        if (!rst_n)         ie_r <= 1'b0;
        else if (reg_wr_en) ie_r <= reg_wr_data[b];
      end
      assign st_q[b]    = ie_r;
      assign st_next[b] = reg_wr_en ? reg_wr_data[b] : ie_r;
    end else begin : g_rsvd
      assign st_q[b]    = 1'b0;
      assign st_next[b] = 1'b0;
    end
  end

  isu_irq_reduce u_irq (.status(st_next), .li_en(li_irq_en), .irq_d(irq_d));

  always_ff @(posedge clk) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= irq_d;
  end

  assign irq         = irq_r;
  assign reg_rd_data = st_q;
  assign smp_ready   = 1'b1;
endmodule

// File: rtl/isu_checker.sv
module isu_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        reg_wr_en,
  input logic [15:0] reg_wr_data,
  input logic [15:0] reg_rd_data,
  input logic [1:0]  gpio_evt,
  input logic        smp_valid,
  input logic        fifo_full,
  input logic        fifo_wr_en,
  input logic        smp_ready,
  input logic        irq
);
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[13:10] == 4'b0000); // R2
  AST_SERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_rd_data[15] && !reg_rd_data[14]) |=> !reg_rd_data[14]); // R3
  AST_GPIO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_evt[0] |=> reg_rd_data[8]); // R6
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_wr_data[9] && !gpio_evt[1]) |=> !reg_rd_data[9]); // R5
  AST_OVR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && fifo_full) |=> reg_rd_data[7]); // R7
  AST_OVR_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[7] |-> !fifo_wr_en); // R8
  AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready); // R7
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[14:5] == 10'b0) |-> !irq); // R10
endmodule

bind isu_top isu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
  .reg_rd_data(reg_rd_data), .gpio_evt(gpio_evt), .smp_valid(smp_valid),
  .fifo_full(fifo_full), .fifo_wr_en(fifo_wr_en), .smp_ready(smp_ready),
  .irq(irq));

// File: tb/isu_top_test.sv
module isu_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int SMP_W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 0; logic [15:0] reg_wr_data = '0;
  logic [15:0] reg_rd_data;
  logic cfg_err_status = 0; logic [1:0] gpio_evt = '0;
  logic li_curr_done = 0, li_last_done = 0; logic [2:0] li_irq_en = '0;
  logic smp_valid = 0, smp_ready; logic [SMP_W-1:0] smp_data = '0;
  logic fifo_full = 0, fifo_wr_en; logic [SMP_W-1:0] fifo_wr_data;
  logic irq;

  isu_top #(.SMP_W(SMP_W)) uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [15:0]      rd;
    logic             irq;
    logic             fwr;
    logic [SMP_W-1:0] fdat;
    string            tag;
  } exp_t;
  exp_t exp_q[$];

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] m_st = '0;
  logic        m_irq = 0;

  // monitor: compares outputs against queued expectations
  always @(negedge clk) begin
    #2;
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (reg_rd_data !== e.rd) begin
        errors++; $display("FAIL %s status act=%h exp=%h", e.tag, reg_rd_data, e.rd);
      end
      checks++;
      if (irq !== e.irq) begin
        errors++; $display("FAIL %s irq act=%b exp=%b", e.tag, irq, e.irq);
      end
      checks++;
      if (fifo_wr_en !== e.fwr || smp_ready !== 1'b1) begin
        errors++; $display("FAIL %s fifo_wr_en/ready act=%b/%b exp=%b/1", e.tag, fifo_wr_en, smp_ready, e.fwr);
      end
      if (e.fwr) begin
        checks++;
        if (fifo_wr_data !== e.fdat) begin
          errors++; $display("FAIL %s fifo_wr_data act=%h exp=%h", e.tag, fifo_wr_data, e.fdat);
        end
      end
    end
  end

  // driver: one cycle of stimulus, expectation from requirement model
  task automatic cyc(input string tag, input logic wr = 0, input logic [15:0] wd = '0,
                     input logic cfg = 0, input logic [1:0] gp = '0, input logic cur = 0,
                     input logic lst = 0, input logic [2:0] en = '0, input logic sv = 0,
                     input logic [SMP_W-1:0] sd = '0, input logic ff = 0);
    exp_t e;
    logic [15:0] n;
    @(negedge clk);
    reg_wr_en = wr; reg_wr_data = wd; cfg_err_status = cfg; gpio_evt = gp;
    li_curr_done = cur; li_last_done = lst; li_irq_en = en;
    smp_valid = sv; smp_data = sd; fifo_full = ff;
    #1;
    e.rd = m_st; e.irq = m_irq; e.fwr = sv & ~ff & ~m_st[7]; e.fdat = sd; e.tag = tag;
    exp_q.push_back(e);
    n = m_st;
    if (wr) begin
      n[15] = wd[15];
      n[14] = n[14] & ~wd[14];
      n[9:5] = n[9:5] & ~wd[9:5];
    end
    if (m_st[15] && cfg) n[14] = 1'b1;
    if (gp[1]) n[9] = 1'b1;
    if (gp[0]) n[8] = 1'b1;
    if (sv && ff) n[7] = 1'b1;
    if (cur) n[6] = 1'b1;
    if (lst) n[5] = 1'b1;
    @(posedge clk);
    m_st = n;
    m_irq = (n[14] & n[15]) | n[9] | n[8] | (|(n[7:5] & en));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1_reset");
    // R4 gpio pins, sticky
    cyc("R4_gp0", .gp(2'b01));
    cyc("R4_hold");
    cyc("R4_gp1", .gp(2'b10));
    cyc("R4_hold2");
    // R5 writing zeros changes nothing, then single-bit clear
    cyc("R5_zero_wr", .wr(1));
    cyc("R5_clr8", .wr(1), .wd(16'h0100));
    cyc("R5_chk");
    // R6 set wins over clear
    cyc("R6_collide", .wr(1), .wd(16'h0200), .gp(2'b10));
    cyc("R6_chk");
    cyc("R5_clr9", .wr(1), .wd(16'h0200));
    // R2 reserved field writes ignored
    cyc("R2_rsvd_wr", .wr(1), .wd(16'h3C00));
    cyc("R2_chk");
    // R3 error bit needs enable and external status
    cyc("R3_no_en", .cfg(1));
    cyc("R3_chk0");
    cyc("R3_set_en", .wr(1), .wd(16'h8000));
    cyc("R3_cfg_low");
    cyc("R3_both", .cfg(1));
    cyc("R3_sticky");
    cyc("R6_serr_collide", .wr(1), .wd(16'hC000), .cfg(1));
    cyc("R5_serr_clr", .wr(1), .wd(16'hC000));
    cyc("R3_dis", .wr(1), .wd(16'h0000));
    cyc("R3_chk1", .cfg(1));
    // R8 samples pass through, R7 overrun drop
    cyc("R8_pass_a", .sv(1), .sd(32'hA5A5_0001));
    cyc("R8_pass_b", .sv(1), .sd(32'h1234_5678));
    cyc("R7_full", .sv(1), .sd(32'hDEAD_0000), .ff(1));
    cyc("R8_blocked", .sv(1), .sd(32'h0000_0042));
    cyc("R8_blocked2", .sv(1), .sd(32'h0000_0043), .en(3'b100));
    cyc("R10_ovr_irq", .en(3'b100));
    cyc("R10_ovr_off", .en(3'b000));
    cyc("R5_clr_ovr", .wr(1), .wd(16'h0080));
    cyc("R8_resume", .sv(1), .sd(32'h0000_0044));
    cyc("R8_full_noflag_idle", .ff(1));
    // R9 descriptor completions, R10 per-enable gating
    cyc("R9_cur", .cur(1));
    cyc("R9_last", .lst(1));
    cyc("R10_en_last", .en(3'b001));
    cyc("R10_en_cur", .en(3'b010));
    cyc("R10_en_none", .en(3'b000));
    cyc("R10_en_all", .en(3'b111));
    cyc("R5_multi_clr", .wr(1), .wd(16'h0060), .en(3'b111));
    cyc("R10_quiet", .en(3'b111));
    // several sources at once
    cyc("R4_multi", .gp(2'b11), .cur(1), .lst(1), .sv(1), .ff(1), .en(3'b111));
    cyc("R5_clr_all", .wr(1), .wd(16'hFFFF));
    cyc("R3_en_left", .wr(1), .wd(16'h0000));
    cyc("R1_end");
    @(negedge clk); #3;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule